// File: doc/BRIEF.md
# Timed SRAM Read Sequencer

This block reads one byte from an asynchronous SRAM-style device. It drives the address bus, a read strobe and a write strobe, and samples the device data bus. The read runs as seven timed steps. A request carries a 16-bit address. When the last step finishes, the block returns the sampled byte together with a one-cycle done pulse.

Each step lasts a number of clock cycles set by a parameter. A wait of zero is treated as one cycle. Four separations between steps have lower and upper bounds, and a parameter set that breaks any bound is rejected when the design is elaborated. Inside a read, the address is driven first and the read strobe rises next. After a settle step the data bus is sampled. The address is then released, the strobe falls, and a final step closes the read. The write strobe stays low for the whole read.

The default waits are 2, 12, 5, 5, 2 and 10 cycles for steps one to six, and step seven lasts one cycle. With these defaults the sample edge is cycle 19 after acceptance and done rises at cycle 37.

Top module: `sram_rd_seq`

## Requirements
- R1: When idle, a high `req_i` at a rising edge is accepted at that edge (edge 0). From that edge, `sram_addr_o` shows `req_addr_i` and `sram_rd_o` is still 0.
- R2: `sram_rd_o` rises at edge D1 after acceptance. `sram_wr_o` is 0 at all times.
- R3: The data bus is sampled at edge D1+D2+D3. `rd_data_o` shows the sampled byte from that edge on.
- R4: `sram_addr_o` holds the request address until edge D1+D2+D3+D4, where it returns to 0.
- R5: `sram_rd_o` falls to 0 at edge D1+…+D5.
- R6: `done_o` is 1 for exactly one cycle, starting at edge D1+…+D6+1. The block is then idle, and a request at the next edge is accepted.
- R7: A `req_i` that arrives while a read is in progress is ignored. The address, strobe and done timing of the current read are unchanged, and no second read follows.
- R8: `rd_data_o` keeps the last sampled byte until the next sample edge, however long the block stays idle.
- R9: A synchronous active-high `rst` returns the block to idle. It sets `sram_addr_o`, `sram_rd_o`, `done_o` and `rd_data_o` to 0.
- R10: Dk is the wait of step k, with 0 counted as 1. The default waits must satisfy four bounds: D1+D2 and D2 in 10..20, D5+D6 in 10..20, and D6 in 5..10. Elaboration rejects any parameter set outside these bounds. At the ports, the strobe fall to the end of step 7 spans 5..10 cycles, and the address release to the end of step 7 spans 10..20 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | Read request, sampled only when idle |
| req_addr_i | input | ADDR_W (16) | Address of the requested byte |
| rd_data_o | output | DATA_W (8) | Last byte sampled from the device |
| done_o | output | 1 | One-cycle pulse when a read completes |
| sram_addr_o | output | ADDR_W (16) | Device address bus |
| sram_rd_o | output | 1 | Read strobe to the device |
| sram_wr_o | output | 1 | Write strobe to the device, held low |
| sram_dq_i | input | DATA_W (8) | Device data bus |

## Verification
The bench changes the device data bus every cycle to a pattern tied to the cycle index. Only a sample taken at exactly the right edge gives the expected byte, so a capture one cycle early or late is caught. Random addresses and data bases, with full-scale and all-zero cases, show that address and data pass through unchanged. Stray requests are injected at random points during a read, and at its first and last busy cycles, to separate a correct idle-only accept from a restart. Back-to-back reads, long idle gaps and a reset in mid-read check the earliest re-accept, data hold and the return to the reset state.

// File: rtl/sram_rd_pkg.sv
package sram_rd_pkg;

   // Step of one read cycle; order is the order of execution.
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,     // step 1: address driven
      ST_STROBE,   // step 2: read strobe raised
      ST_SETTLE,   // step 3: wait only
      ST_SAMPLE,   // step 4: data bus captured on entry
      ST_RELEASE,  // step 5: address returned to zero
      ST_CLOSE,    // step 6: strobes dropped
      ST_TAIL      // step 7: wait only
   } rd_step_e;

   // A wait of zero still occupies one clock cycle.
   function automatic int unsigned eff_wait(input int unsigned w);
      return (w == 0) ? 1 : w;
   endfunction

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/rd_wait_timer.sv
module rd_wait_timer #(
   parameter int unsigned CNT_MAX = 12,
   parameter int unsigned CW      = 4
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          expired
);

   generate
      if (CNT_MAX <= 1) begin : g_no_count
         // Every step lasts a single cycle: no counter is needed.
         logic unused_ok;
         assign unused_ok = ^{clk, rst, load, load_val};
         assign expired   = 1'b1;
      end else begin : g_count
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk) begin
            if (rst) begin
               cnt_q <= '0;
            end else if (load) begin
               cnt_q <= load_val;
            end else if (cnt_q != '0) begin
               cnt_q <= cnt_q - 1'b1;
            end
         end

         assign expired = (cnt_q == '0);

         AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (rst)
            (!load && cnt_q != '0) |=> (cnt_q == CW'($past(cnt_q) - 1'b1)))
            else $error("wait counter skipped a step"); // R10
      end
   endgenerate

endmodule

// File: rtl/rd_step_fsm.sv
module rd_step_fsm
   import sram_rd_pkg::*;
#(
   parameter int unsigned D1 = 2,
   parameter int unsigned D2 = 12,
   parameter int unsigned D3 = 5,
   parameter int unsigned D4 = 5,
   parameter int unsigned D5 = 2,
   parameter int unsigned D6 = 10,
   parameter int unsigned D7 = 1,
   parameter int unsigned CW = 4
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          req,
   input  logic          expired,
   output logic          load,
   output logic [CW-1:0] load_val,
   output logic          go_addr,
   output logic          go_strobe,
   output logic          go_sample,
   output logic          go_release,
   output logic          go_close,
   output logic          go_finish
);

   rd_step_e state_q, state_d;

   // Counter preload for a step: duration minus one.
   function automatic logic [CW-1:0] preload(input rd_step_e s);
      case (s)
         ST_ADDR:    return CW'(D1 - 1);
         ST_STROBE:  return CW'(D2 - 1);
         ST_SETTLE:  return CW'(D3 - 1);
         ST_SAMPLE:  return CW'(D4 - 1);
         ST_RELEASE: return CW'(D5 - 1);
         ST_CLOSE:   return CW'(D6 - 1);
         ST_TAIL:    return CW'(D7 - 1);
         default:    return '0;
      endcase
   endfunction

   always_comb begin
      state_d = state_q;
      load    = 1'b0;
      if (state_q == ST_IDLE) begin
         if (req) begin
            state_d = ST_ADDR;
            load    = 1'b1;
         end
      end else if (expired) begin
         load    = 1'b1;
         state_d = (state_q == ST_TAIL) ? ST_IDLE : rd_step_e'(state_q + 3'd1);
      end
      load_val = preload(state_d);
   end

   always_ff @(posedge clk) begin
      if (rst) state_q <= ST_IDLE;
      else     state_q <= state_d;
   end

   assign go_addr    = (state_q == ST_IDLE) && req;
   assign go_strobe  = (state_q == ST_ADDR)    && expired;
   assign go_sample  = (state_q == ST_SETTLE)  && expired;
   assign go_release = (state_q == ST_SAMPLE)  && expired;
   assign go_close   = (state_q == ST_RELEASE) && expired;
   assign go_finish  = (state_q == ST_TAIL)    && expired;

   AST_ACCEPT_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_ADDR && $past(state_q) != ST_ADDR) |-> ($past(state_q) == ST_IDLE))
      else $error("read started outside idle"); // R7

endmodule

// File: rtl/rd_bus_regs.sv
module rd_bus_regs #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              go_addr,
   input  logic              go_strobe,
   input  logic              go_sample,
   input  logic              go_release,
   input  logic              go_close,
   input  logic              go_finish,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] dq,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_rd,
   output logic [DATA_W-1:0] rd_data,
   output logic              done
);

   logic [ADDR_W-1:0] addr_q;
   logic              rd_q;
   logic [DATA_W-1:0] data_q;
   logic              done_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         addr_q <= '0;
         rd_q   <= 1'b0;
         data_q <= '0;
         done_q <= 1'b0;
      end else begin
         if (go_addr)         addr_q <= req_addr;
         else if (go_release) addr_q <= '0;
         if (go_strobe)       rd_q   <= 1'b1;
         else if (go_close)   rd_q   <= 1'b0;
         if (go_sample)       data_q <= dq;
         done_q <= go_finish;
      end
   end

   assign bus_addr = addr_q;
   assign bus_rd   = rd_q;
   assign rd_data  = data_q;
   assign done     = done_q;

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      done_q |=> !done_q)
      else $error("done held longer than one cycle"); // R6

   AST_ADDR_GONE_AT_CLOSE: assert property (@(posedge clk) disable iff (rst)
      $fell(rd_q) |-> (addr_q == '0))
      else $error("strobe fell before address release"); // R5

endmodule

// File: rtl/sram_rd_seq.sv
module sram_rd_seq
   import sram_rd_pkg::*;
#(
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned WAIT_S1  = 2,
   parameter int unsigned WAIT_S2  = 12,
   parameter int unsigned WAIT_S3  = 5,
   parameter int unsigned WAIT_S4  = 5,
   parameter int unsigned WAIT_S5  = 2,
   parameter int unsigned WAIT_S6  = 10,
   parameter int unsigned LONG_MIN = 10,
   parameter int unsigned LONG_MAX = 20,
   parameter int unsigned SHORT_MIN = 5,
   parameter int unsigned SHORT_MAX = 10
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_i,
   input  logic [ADDR_W-1:0] req_addr_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              done_o,
   output logic [ADDR_W-1:0] sram_addr_o,
   output logic              sram_rd_o,
   output logic              sram_wr_o,
   input  logic [DATA_W-1:0] sram_dq_i
);

   localparam int unsigned D1 = eff_wait(WAIT_S1);
   localparam int unsigned D2 = eff_wait(WAIT_S2);
   localparam int unsigned D3 = eff_wait(WAIT_S3);
   localparam int unsigned D4 = eff_wait(WAIT_S4);
   localparam int unsigned D5 = eff_wait(WAIT_S5);
   localparam int unsigned D6 = eff_wait(WAIT_S6);
   localparam int unsigned D7 = 1;
   localparam int unsigned CNT_MAX =
      max2(max2(max2(D1, D2), max2(D3, D4)), max2(max2(D5, D6), D7));
   localparam int unsigned CW = (CNT_MAX > 1) ? $clog2(CNT_MAX) : 1;

   // Elaboration checks of the step windows.
   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("bus widths must be at least one bit");
      end
      if (D1 + D2 < LONG_MIN || D1 + D2 > LONG_MAX) begin : g_bad_s1_s3
         $error("step 1 to step 3 separation out of window");
      end
      if (D2 < LONG_MIN || D2 > LONG_MAX) begin : g_bad_s2_s3
         $error("step 2 to step 3 separation out of window");
      end
      if (D5 + D6 < LONG_MIN || D5 + D6 > LONG_MAX) begin : g_bad_s5_s7
         $error("step 5 to step 7 separation out of window");
      end
      if (D6 < SHORT_MIN || D6 > SHORT_MAX) begin : g_bad_s6_s7
         $error("step 6 to step 7 separation out of window");
      end
   endgenerate

   logic          load, expired;
   logic [CW-1:0] load_val;
   logic          go_addr, go_strobe, go_sample, go_release, go_close, go_finish;

   rd_wait_timer #(.CNT_MAX(CNT_MAX), .CW(CW)) i_timer (
      .clk      (clk),
      .rst      (rst),
      .load     (load),
      .load_val (load_val),
      .expired  (expired)
   );

   rd_step_fsm #(
      .D1(D1), .D2(D2), .D3(D3), .D4(D4), .D5(D5), .D6(D6), .D7(D7), .CW(CW)
   ) i_fsm (
      .clk        (clk),
      .rst        (rst),
      .req        (req_i),
      .expired    (expired),
      .load       (load),
      .load_val   (load_val),
      .go_addr    (go_addr),
      .go_strobe  (go_strobe),
      .go_sample  (go_sample),
      .go_release (go_release),
      .go_close   (go_close),
      .go_finish  (go_finish)
   );

   rd_bus_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_regs (
      .clk        (clk),
      .rst        (rst),
      .go_addr    (go_addr),
      .go_strobe  (go_strobe),
      .go_sample  (go_sample),
      .go_release (go_release),
      .go_close   (go_close),
      .go_finish  (go_finish),
      .req_addr   (req_addr_i),
      .dq         (sram_dq_i),
      .bus_addr   (sram_addr_o),
      .bus_rd     (sram_rd_o),
      .rd_data    (rd_data_o),
      .done       (done_o)
   );

   assign sram_wr_o = 1'b0;

   AST_IDLE_BUS_AT_DONE: assert property (@(posedge clk) disable iff (rst)
      done_o |-> (!sram_rd_o && sram_addr_o == '0))
      else $error("bus not released when read completes"); // R6

endmodule

// File: tb/test_sram_rd_seq.sv
`timescale 1ns/1ps
module test_sram_rd_seq;

   localparam int AW = 16;
   localparam int DW = 8;
   localparam int W1 = 2, W2 = 12, W3 = 5, W4 = 5, W5 = 2, W6 = 10;

   function automatic int effw(input int w);
      return (w == 0) ? 1 : w;
   endfunction

   localparam int D1 = effw(W1);
   localparam int D2 = effw(W2);
   localparam int D3 = effw(W3);
   localparam int D4 = effw(W4);
   localparam int D5 = effw(W5);
   localparam int D6 = effw(W6);
   localparam int E_RD_UP   = D1;
   localparam int E_SAMPLE  = D1 + D2 + D3;
   localparam int E_ADDR0   = E_SAMPLE + D4;
   localparam int E_RD_DOWN = E_ADDR0 + D5;
   localparam int E_DONE    = E_RD_DOWN + D6 + 1;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          req = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] dq = '0;
   logic [DW-1:0] rd_data;
   logic          done;
   logic [AW-1:0] sram_addr;
   logic          sram_rd, sram_wr;

   int n_chk = 0;
   int n_fail = 0;
   logic [DW-1:0] exp_data = '0;

   always #2 clk = ~clk;

   sram_rd_seq #(
      .ADDR_W(AW), .DATA_W(DW),
      .WAIT_S1(W1), .WAIT_S2(W2), .WAIT_S3(W3),
      .WAIT_S4(W4), .WAIT_S5(W5), .WAIT_S6(W6)
   ) i_sram_rd_seq (
      .clk(clk), .rst(rst), .req_i(req), .req_addr_i(req_addr),
      .rd_data_o(rd_data), .done_o(done), .sram_addr_o(sram_addr),
      .sram_rd_o(sram_rd), .sram_wr_o(sram_wr), .sram_dq_i(dq)
   );

   task automatic check(input bit ok, input string rq, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", rq, act, exp, $time);
      end
   endtask

   function automatic logic [DW-1:0] pat(input logic [DW-1:0] base, input int j);
      return base ^ DW'(j);
   endfunction

   // One read: request set before edge 0, checks after each edge j.
   task automatic run_read(input logic [AW-1:0] a, input logic [DW-1:0] base, input int inj);
      int rd_fall = -1, addr_rel = -1, done_at = -1;
      @(negedge clk);
      req = 1'b1; req_addr = a; dq = base;
      for (int j = 0; j <= E_DONE; j++) begin
         @(negedge clk);
         if (j == 0) begin req = 1'b0; req_addr = AW'($urandom); end
         begin
            logic [AW-1:0] ea;
            logic          er;
            ea = (j < E_ADDR0) ? a : '0;
            er = (j >= E_RD_UP) && (j < E_RD_DOWN);
            if (inj >= 0 && j > inj)
               check(sram_addr == ea, "R7 addr", sram_addr, ea);
            else if (j < E_ADDR0)
               check(sram_addr == ea, "R1 addr", sram_addr, ea);
            else
               check(sram_addr == ea, "R4 addr", sram_addr, ea);
            if (j == 0) check(sram_rd == 1'b0, "R1 rd", sram_rd, 0);
            else if (j < E_RD_DOWN) check(sram_rd == er, "R2 rd", sram_rd, er);
            else check(sram_rd == er, "R5 rd", sram_rd, er);
            check(sram_wr == 1'b0, "R2 wr", sram_wr, 0);
            check(done == (j == E_DONE), "R6 done", done, (j == E_DONE));
            if (j >= E_SAMPLE)
               check(rd_data == pat(base, E_SAMPLE - 1), "R3 data", rd_data, pat(base, E_SAMPLE - 1));
            else
               check(rd_data == exp_data, "R8 data", rd_data, exp_data);
         end
         if (sram_addr == '0 && addr_rel < 0 && j > 0) addr_rel = j;
         if (!sram_rd && rd_fall < 0 && j > E_RD_UP) rd_fall = j;
         if (done && done_at < 0) done_at = j;
         dq = pat(base, j);
         if (inj >= 0 && j == inj) begin req = 1'b1; req_addr = ~a; end
         if (inj >= 0 && j == inj + 1) req = 1'b0;
      end
      exp_data = pat(base, E_SAMPLE - 1);
      // R10: window check from observed edges (end of step 7 = done edge - 1)
      if (a != '0) check((done_at - 1 - addr_rel) >= 10 && (done_at - 1 - addr_rel) <= 20,
                         "R10 addr-release window", done_at - 1 - addr_rel, 15);
      check((done_at - 1 - rd_fall) >= 5 && (done_at - 1 - rd_fall) <= 10,
            "R10 strobe-fall window", done_at - 1 - rd_fall, 10);
   endtask

   task automatic idle_hold(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         dq = DW'($urandom);
         check(rd_data == exp_data, "R8 hold", rd_data, exp_data);
         check(sram_addr == '0 && !sram_rd && !done, "R6 idle", {sram_addr, sram_rd, done}, 0);
      end
   endtask

   initial begin
      #(4 * 150000);
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'h1f3a));
      repeat (3) @(negedge clk);
      check(sram_addr == '0, "R9 reset addr", sram_addr, 0);
      check(!sram_rd && !sram_wr, "R9 reset strobes", {sram_rd, sram_wr}, 0);
      check(!done, "R9 reset done", done, 0);
      check(rd_data == '0, "R9 reset data", rd_data, 0);
      rst = 1'b0;

      // directed corners
      run_read(16'hFFFF, 8'hFF, -1);
      run_read(16'h0000, 8'h00, 0);
      run_read(16'hA5C3, 8'h3C, E_DONE - 2);
      run_read(16'h1234, 8'h81, -1);         // back-to-back accept (R6)
      idle_hold(25);

      // random reads
      for (int n = 0; n < 14; n++) begin
         logic [AW-1:0] a;
         logic [DW-1:0] b;
         int inj;
         a   = AW'($urandom);
         b   = DW'($urandom);
         inj = ($urandom % 2) ? int'($urandom % (E_DONE - 1)) : -1;
         run_read(a, b, inj);
         idle_hold(int'($urandom % 6));
      end

      // reset in the middle of a read
      @(negedge clk);
      req = 1'b1; req_addr = 16'h7E01;
      @(negedge clk);
      req = 1'b0;
      repeat (E_RD_UP + 3) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      check(sram_addr == '0, "R9 mid reset addr", sram_addr, 0);
      check(!sram_rd, "R9 mid reset rd", sram_rd, 0);
      check(!done, "R9 mid reset done", done, 0);
      check(rd_data == '0, "R9 mid reset data", rd_data, 0);
      rst = 1'b0;
      exp_data = '0;
      idle_hold(3);
      run_read(16'h4242, 8'h5A, -1);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule